// File: doc/BRIEF.md
# Batched Sample Output Buffer

This block sits between a converter's output word stream and a host. One 16-bit sample arrives with a valid strobe every 8 clock cycles. A 3-bit level input sets a batch size. The block stores incoming samples in a ring and raises a one-cycle ready strobe each time a full batch has been collected. The host then pulls the batch out through an active-low chip select and an active-low read strobe. Both are sampled on the block's clock. Each falling read edge presents the next word, oldest first.

The host must take exactly one whole batch per ready strobe. It may also leave a batch untouched. In that case the buffer drops the batch and the next ready strobe comes a fixed 16 samples (128 clocks) after the previous one. A read with nothing pending is an error, and so is a readback still incomplete when the next batch interval ends. Either error locks the block silent until a reset followed by a read pulse. Level code 000 turns batching off, so that every sample produces its own ready strobe.

Top module: `burst_sample_fifo`

## Requirements
- R1: After reset `rdy` and `dout` are 0 and no ready strobe is produced until a falling read edge (`rd_n` high then low on consecutive clocks with `cs_n` low). That wake edge leaves `dout` unchanged.
- R2: With `lvl` = 000, every accepted sample gives `rdy` high in the next cycle. A falling read edge presents the most recent sample. Unread samples never cause an error.
- R3: With `lvl` = c (1 to 7) the batch size is 2·c words. `rdy` is high for exactly one cycle, the cycle after the sample that completes the batch. With samples every 8 clocks, consecutive strobes are 16·c clocks apart.
- R4: A falling read edge updates `dout` in the following cycle. The words of a batch appear oldest first, in arrival order, and the batch is the 2·c samples ending with the one that raised `rdy`.
- R5: Once all 2·c words are read, the next strobe follows 2·c samples after the previous one and carries the next 2·c samples.
- R6: If no word of a batch is read, no strobe occurs after 2·c samples. Instead the next strobe comes 16 samples (128 clocks) after the previous one and carries the latest 2·c samples. Reading that batch fully restores the normal period.
- R7: A falling read edge when no batch is pending enters a stall. While stalled, `rdy` stays 0 and read edges leave `dout` unchanged.
- R8: If 2·c samples arrive after a strobe while that batch is only partly read, the block stalls as in R7.
- R9: A stall persists until reset. After the reset the block behaves as in R1 and needs a read pulse before the next batch.
- R10: While `cs_n` is high, read edges are ignored, do not count as reads, and `dout` holds.
- R11: `lvl` is used live. A change made during a readback leaves the count of the open batch unchanged, and the next strobe follows the new size counted from the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl | input | 3 | Batch level code (000 bypass, c gives 2·c words) |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 16 | Sample word |
| cs_n | input | 1 | Active-low chip select for reads |
| rd_n | input | 1 | Active-low read strobe, falling edge advances |
| dout | output | 16 | Read data |
| rdy | output | 1 | Batch ready strobe |

## Verification
The checker watches the per-cycle rules on every clock:
- a ready strobe always follows an accepted sample;
- bypass answers each sample;
- the wake and stall states keep the strobe low;
- a stall is sticky;
- chip select high freezes the output.

The bench scenarios cover what spans many samples:
- the strobe period for several levels and the 128-clock stretch after a skipped batch;
- the oldest-first order of the words;
- the two read-count errors and the reset-plus-read recovery;
- a level change made in the middle of a readback.

// File: rtl/burst_sample_fifo.sv
`timescale 1ns/1ps
module burst_sample_fifo #(
  parameter int DW = 16,
  parameter int LW = 3,
  parameter int DEPTH = 32,
  parameter int SKIP_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lvl,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          cs_n,
  input  logic          rd_n,
  output logic [DW-1:0] dout,
  output logic          rdy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(SKIP_WORDS + 1);

  typedef enum logic [2:0] {S_WAKE, S_COLL, S_PEND, S_READ, S_STALL} st_t;

  st_t st, st_d;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] latest;
  logic [AW-1:0] wptr, base, base_d;
  logic [CW-1:0] cnt, cnt_d, cnt_inc, rcnt, rcnt_d, rlen, rlen_d, size;
  logic rd_q, fall, byp, fire, take, byp_take;
  logic stalled, asleep;

  assign size    = CW'(lvl) << 1;
  assign byp     = (lvl == '0);
  assign fall    = rd_q & ~rd_n & ~cs_n;
  assign cnt_inc = (smp_valid && cnt != CW'(SKIP_WORDS)) ? cnt + CW'(1) : cnt;
  assign stalled = (st == S_STALL);
  assign asleep  = (st == S_WAKE);

  always_comb begin
    st_d = st;
    cnt_d = cnt;
    rcnt_d = rcnt;
    rlen_d = rlen;
    base_d = base;
    fire = 1'b0;
    take = 1'b0;
    byp_take = 1'b0;
    case (st)
      S_WAKE: begin
        if (fall) begin
          st_d = S_COLL;
          cnt_d = '0;
        end
      end
      S_STALL: ;
      default: begin
        if (byp) begin
          fire = smp_valid;
          byp_take = fall;
        end else begin
          cnt_d = cnt_inc;
          if (fall) begin
            if (st == S_COLL) begin
              st_d = S_STALL;
            end else begin
              take = 1'b1;
              if (rcnt + CW'(1) == rlen) begin
                st_d = S_COLL;
                rcnt_d = '0;
              end else begin
                st_d = S_READ;
                rcnt_d = rcnt + CW'(1);
              end
            end
          end
          if (smp_valid && st_d != S_STALL) begin
            if ((st_d == S_COLL && cnt_inc >= size) ||
                (st_d == S_PEND && cnt_inc == CW'(SKIP_WORDS))) begin
              fire = 1'b1;
              st_d = S_PEND;
              cnt_d = '0;
              rcnt_d = '0;
              rlen_d = size;
              base_d = wptr - AW'(size) + AW'(1);
            end else if (st_d == S_READ && cnt_inc >= size) begin
              st_d = S_STALL;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (smp_valid) mem[wptr] <= smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAKE;
      cnt <= '0;
      rcnt <= '0;
      rlen <= '0;
      base <= '0;
      wptr <= '0;
      latest <= '0;
      rd_q <= 1'b1;
      dout <= '0;
      rdy <= 1'b0;
    end else begin
      st <= st_d;
      cnt <= cnt_d;
      rcnt <= rcnt_d;
      rlen <= rlen_d;
      base <= base_d;
      rd_q <= rd_n;
      rdy <= fire;
      if (smp_valid) begin
        wptr <= wptr + AW'(1);
        latest <= smp_data;
      end
      if (take) dout <= mem[base + AW'(rcnt)];
      else if (byp_take) dout <= latest;
    end
  end
endmodule

module burst_sample_fifo_chk #(
  parameter int DW = 16,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] lvl,
  input logic          smp_valid,
  input logic          cs_n,
  input logic [DW-1:0] dout,
  input logic          rdy,
  input logic          stalled,
  input logic          asleep
);
  AST_RDY_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) rdy |-> $past(smp_valid)); // R3
  AST_BYPASS_EACH: assert property (@(posedge clk) disable iff (!rst_n) (lvl == '0 && smp_valid && !stalled && !asleep) |=> rdy); // R2
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) asleep |=> !rdy); // R1
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stalled |=> !rdy); // R7
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) stalled |=> stalled); // R9
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> $stable(dout)); // R10
endmodule

bind burst_sample_fifo burst_sample_fifo_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(lvl), .smp_valid(smp_valid), .cs_n(cs_n),
  .dout(dout), .rdy(rdy), .stalled(stalled), .asleep(asleep)
);

// File: tb/burst_sample_fifo_bench.sv
`timescale 1ns/1ps
module burst_sample_fifo_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] lvl = 3'd0;
  logic smp_valid;
  logic [15:0] smp_data;
  logic cs_n = 1'b0;
  logic rd_n = 1'b1;
  logic [15:0] dout;
  logic rdy;

  burst_sample_fifo u_burst_sample_fifo (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .smp_valid(smp_valid), .smp_data(smp_data),
    .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .rdy(rdy)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rdy_seen = 0;
  int ph = 0;
  logic [15:0] seq = 16'h1000;
  logic [15:0] last_data = 16'h0;

  always @(posedge clk) begin
    cyc++;
    if (rdy) rdy_seen++;
  end

  initial begin
    smp_valid = 1'b0;
    smp_data = '0;
    forever begin
      @(negedge clk);
      if (ph == 7) begin
        smp_valid = 1'b1;
        smp_data = seq;
        last_data = seq;
        seq = seq + 16'd1;
        ph = 0;
      end else begin
        smp_valid = 1'b0;
        ph++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] l);
    lvl = l;
    cs_n = 1'b0;
    rd_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_word(output logic [15:0] v);
    rd_n = 1'b0;
    @(negedge clk);
    v = dout;
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output int t, output logic [15:0] ld, output bit ok);
    ok = 1'b0;
    t = 0;
    ld = '0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rdy) begin
        t = cyc;
        ld = last_data;
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic read_batch(int n, logic [15:0] ld, string tag);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      read_word(v);
      chk(tag, v, ld - 16'(n) + 16'd1 + 16'(i));
    end
  endtask

  task automatic t_reset_wake();
    int s, t;
    logic [15:0] ld;
    bit ok;
    do_reset(3'd2);
    chk("R1 rdy after reset", rdy, 0);
    chk("R1 dout after reset", dout, 0);
    s = rdy_seen;
    repeat (120) @(negedge clk);
    chk("R1 no strobe before wake", rdy_seen - s, 0);
    pulse_rd();
    chk("R1 wake leaves dout", dout, 0);
    wait_rdy(t, ld, ok);
    chk("R1 strobe after wake", ok, 1);
  endtask

  task automatic t_batches();
    int t1, t2;
    logic [15:0] ld1, ld2;
    bit ok;
    for (int c = 1; c <= 7; c += 3) begin
      do_reset(3'(c));
      pulse_rd();
      wait_rdy(t1, ld1, ok);
      chk("R3 first strobe", ok, 1);
      @(negedge clk);
      chk("R3 strobe one cycle", rdy, 0);
      read_batch(2 * c, ld1, "R4 batch order");
      wait_rdy(t2, ld2, ok);
      chk("R5 next strobe", ok, 1);
      chk("R3 R5 period", t2 - t1, 16 * c);
      read_batch(2 * c, ld2, "R5 next batch data");
    end
  endtask

  task automatic t_skip();
    int t1, t2, t3;
    logic [15:0] ld1, ld2, ld3;
    bit ok;
    do_reset(3'd3);
    pulse_rd();
    wait_rdy(t1, ld1, ok);
    wait_rdy(t2, ld2, ok);
    chk("R6 skip strobe", ok, 1);
    chk("R6 skip period", t2 - t1, 128);
    read_batch(6, ld2, "R6 latest words");
    wait_rdy(t3, ld3, ok);
    chk("R6 normal period after read", t3 - t2, 48);
    read_batch(6, ld3, "R6 data after skip");
  endtask

  task automatic t_err_extra();
    int t, s;
    logic [15:0] ld, d;
    bit ok;
    do_reset(3'd2);
    pulse_rd();
    wait_rdy(t, ld, ok);
    read_batch(4, ld, "R4 before extra read");
    pulse_rd();
    s = rdy_seen;
    d = dout;
    repeat (200) @(negedge clk);
    chk("R7 stalled no strobe", rdy_seen - s, 0);
    pulse_rd();
    chk("R7 stalled dout frozen", dout, d);
    do_reset(3'd2);
    s = rdy_seen;
    repeat (100) @(negedge clk);
    chk("R9 reset alone silent", rdy_seen - s, 0);
    pulse_rd();
    wait_rdy(t, ld, ok);
    chk("R9 strobe after reset and read", ok, 1);
    read_batch(4, ld, "R9 data after recovery");
  endtask

  task automatic t_err_short();
    int t, s;
    logic [15:0] ld, d;
    bit ok;
    do_reset(3'd2);
    pulse_rd();
    wait_rdy(t, ld, ok);
    read_batch(2, ld - 16'd2, "R4 partial words");
    s = rdy_seen;
    d = dout;
    repeat (200) @(negedge clk);
    chk("R8 short read stalls", rdy_seen - s, 0);
    pulse_rd();
    chk("R8 stalled dout frozen", dout, d);
  endtask

  task automatic t_cs();
    int t1, t2;
    logic [15:0] ld1, ld2, d;
    bit ok;
    do_reset(3'd2);
    pulse_rd();
    wait_rdy(t1, ld1, ok);
    d = dout;
    cs_n = 1'b1;
    pulse_rd();
    pulse_rd();
    chk("R10 dout holds", dout, d);
    cs_n = 1'b0;
    read_batch(4, ld1, "R10 edges not counted");
    wait_rdy(t2, ld2, ok);
    chk("R10 period intact", t2 - t1, 32);
  endtask

  task automatic t_bypass();
    int t1, t2, t3;
    logic [15:0] ld1, ld2, ld3, v;
    bit ok;
    do_reset(3'd0);
    pulse_rd();
    wait_rdy(t1, ld1, ok);
    chk("R2 bypass strobe", ok, 1);
    read_word(v);
    chk("R2 bypass word", v, ld1);
    wait_rdy(t2, ld2, ok);
    wait_rdy(t3, ld3, ok);
    chk("R2 bypass period", t2 - t1, 8);
    chk("R2 unread sample no penalty", t3 - t2, 8);
    read_word(v);
    chk("R2 no stall in bypass", v, ld3);
  endtask

  task automatic t_level();
    int t1, t2, t3;
    logic [15:0] ld1, ld2, ld3, v;
    bit ok;
    do_reset(3'd2);
    pulse_rd();
    wait_rdy(t1, ld1, ok);
    read_word(v);
    chk("R11 first word", v, ld1 - 16'd3);
    lvl = 3'd4;
    for (int i = 1; i < 4; i++) begin
      read_word(v);
      chk("R11 open batch count kept", v, ld1 - 16'd3 + 16'(i));
    end
    wait_rdy(t2, ld2, ok);
    chk("R11 new period", t2 - t1, 64);
    read_batch(8, ld2, "R11 new size data");
    wait_rdy(t3, ld3, ok);
    chk("R11 period stays", t3 - t2, 64);
  endtask

  initial begin
    t_reset_wake();
    t_batches();
    t_skip();
    t_err_extra();
    t_err_short();
    t_cs();
    t_bypass();
    t_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule